// File: doc/BRIEF.md
# Three-Bank Interrupt Status Aggregator

The block gathers twenty-four single-bit event sources into three eight-bit status banks. Each bank has two eight-bit masks. The status mask decides whether a rising edge on a source is recorded at all. The line mask decides whether a recorded bit drives the single active-high interrupt output towards the host.

The host reaches the block through a byte-wide register port. An access opens with a start strobe that loads an address. Each read or write strobe then uses the current address and steps it by one. A three-byte burst can therefore read all status banks in a row, or write all three masks of one kind.

Clearing is done as a group. One byte write of any value to any status bank wipes all twenty-four status bits. A source edge that lands in the same cycle as that clear is still recorded, so the event is not lost.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status bit is 0, all six mask registers read 0xFF, `irqOut` is low and `hostRdValid` is low.
- R2: Source n maps to status bank n/8, bit n%8. Banks 0, 1 and 2 sit at addresses 0x0, 0x1 and 0x2. A 0-to-1 transition of a source, seen at a clock edge, sets its status bit. A source that stays high sets it only once, so after a clear a steady-high source does not set the bit again.
- R3: Status-mask registers sit at addresses 0x6, 0x7 and 0x8 (banks 0, 1, 2), with 1 meaning masked. An edge that arrives while its status-mask bit is 1 is not recorded, and it is not recorded later when the mask is lowered.
- R4: A set status bit stays set, whatever the sources do, until a group clear.
- R5: A single write of any data value to address 0x0, 0x1 or 0x2 clears all twenty-four status bits on the next clock.
- R6: An unmasked source edge in the same cycle as a group clear leaves that source's status bit set after the clear.
- R7: Sources 12 and 23 are reserved. Their status bits never set and always read as 0.
- R8: Line-mask registers sit at addresses 0x3, 0x4 and 0x5 (banks 0, 1, 2), with 1 meaning masked. `irqOut` is high exactly when some status bit is 1 and its line-mask bit is 0. A line-mask write changes `irqOut` from the next clock edge.
- R9: After `hostStart`, each read or write strobe steps the address by one. A three-read burst from 0x0 returns banks 0, 1 and 2 in that order. A three-write burst from 0x6 loads the three status masks in order.
- R10: Reads of addresses 0x9 to 0xF return 0x00. Writes to those addresses change no register.
- R11: `hostRdData` holds the addressed byte in the cycle after a read strobe, with `hostRdValid` high for exactly that one cycle for each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcEvt | input | 24 | Synchronous event sources, one bit per source |
| hostStart | input | 1 | Loads `hostAddr` as the address of this cycle's access and of the burst that follows |
| hostAddr | input | 4 | Start address of an access |
| hostWrEn | input | 1 | Write strobe for the current address |
| hostWrData | input | 8 | Write data |
| hostRdEn | input | 1 | Read strobe for the current address |
| hostRdData | output | 8 | Read data, registered |
| hostRdValid | output | 1 | High in the cycle that `hostRdData` holds a result |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
Latching is tried with single pulses on sources spread over all three banks, including both reserved positions, so that a wrong bank/bit mapping or a reserved bit that latches shows up as a different burst readout. A pulse under a raised status mask, followed by lowering that mask, separates gating at capture time from gating at readout time. A source held high across a clear separates edge detection from level sensing. A pulse in the same cycle as a clear checks the rule that the new event is kept. The interrupt line is watched while line masks open and close around bits that are already latched, and writes to unmapped addresses are followed by a full mask readback.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int BANK_CNT = 3;
  parameter int BANK_W   = 8;
  parameter int ADDR_W   = 4;
  parameter int SRC_CNT  = BANK_CNT * BANK_W;
  // reserved source positions: 12 and 23
  parameter logic [SRC_CNT-1:0] RSV_SRC = (SRC_CNT'(1) << 12) | (SRC_CNT'(1) << 23);

  typedef struct packed {
    logic                clrAll;
    logic [BANK_CNT-1:0] wrLine;
    logic [BANK_CNT-1:0] wrStat;
    logic [BANK_W-1:0]   wrData;
    logic                rdEn;
    logic [ADDR_W-1:0]   rdAddr;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int BW = 8,
  parameter logic [BW-1:0] RSV_BITS = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [BW-1:0] rise,
  input  logic          clrAll,
  input  logic          wrLine,
  input  logic          wrStat,
  input  logic [BW-1:0] wrData,
  output logic [BW-1:0] stat,
  output logic [BW-1:0] lineMask,
  output logic [BW-1:0] statMask,
  output logic          pend
);
  logic [BW-1:0] arm;

  // an edge counts only when enabled and not on a reserved position
  assign arm = rise & ~statMask & ~RSV_BITS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat     <= '0;
      lineMask <= '1;
      statMask <= '1;
    end else begin
      if (clrAll) stat <= arm;
      else        stat <= stat | arm;
      if (wrLine) lineMask <= wrData;
      if (wrStat) statMask <= wrData;
    end
  end

  assign pend = |(stat & ~lineMask);

  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ((stat & ~$past(stat)) & ~$past(rise & ~statMask)) == '0);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !clrAll |=> (stat & $past(stat)) == $past(stat));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (stat & ~$past(rise & ~statMask)) == '0);
  a_r6_clear_keeps_edge: assert property (@(posedge clk) disable iff (!rstN)
    (clrAll && arm != '0) |=> (stat & $past(arm)) == $past(arm));
  a_r7_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (stat & RSV_BITS) == '0);
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStart,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [BANK_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output ctlStrobe_t        ctl
);
  localparam int STAT_BASE = 0;
  localparam int LINE_BASE = BANK_CNT;
  localparam int SMSK_BASE = 2 * BANK_CNT;

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] effAddr;
  logic              acc;

  assign effAddr = hostStart ? hostAddr : ptr;
  assign acc     = hostRdEn | hostWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ptr <= '0;
    else if (acc)       ptr <= effAddr + ADDR_W'(1);
    else if (hostStart) ptr <= hostAddr;
  end

  always_comb begin
    ctl        = '0;
    ctl.wrData = hostWrData;
    ctl.rdEn   = hostRdEn;
    ctl.rdAddr = effAddr;
    for (int b = 0; b < BANK_CNT; b++) begin
      if (hostWrEn && effAddr == ADDR_W'(STAT_BASE + b)) ctl.clrAll    = 1'b1;
      if (hostWrEn && effAddr == ADDR_W'(LINE_BASE + b)) ctl.wrLine[b] = 1'b1;
      if (hostWrEn && effAddr == ADDR_W'(SMSK_BASE + b)) ctl.wrStat[b] = 1'b1;
    end
  end

  a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> ptr == $past(effAddr) + ADDR_W'(1));
  a_r5_one_clear_src: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.clrAll, |ctl.wrLine, |ctl.wrStat}));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_CNT-1:0] srcEvt,
  input  ctlStrobe_t         ctl,
  output logic [BANK_W-1:0]  rdData,
  output logic               rdValid,
  output logic               irqOut
);
  localparam int LINE_BASE = BANK_CNT;
  localparam int SMSK_BASE = 2 * BANK_CNT;

  logic [SRC_CNT-1:0]  srcPrev;
  logic [SRC_CNT-1:0]  rise;
  logic [BANK_W-1:0]   statV  [BANK_CNT];
  logic [BANK_W-1:0]   lineV  [BANK_CNT];
  logic [BANK_W-1:0]   smskV  [BANK_CNT];
  logic [BANK_CNT-1:0] pendV;
  logic [BANK_W-1:0]   rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrev <= '0;
    else       srcPrev <= srcEvt;
  end
  assign rise = srcEvt & ~srcPrev;

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    irq_agg_bank #(
      .BW(BANK_W),
      .RSV_BITS(RSV_SRC[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .rise    (rise[b*BANK_W +: BANK_W]),
      .clrAll  (ctl.clrAll),
      .wrLine  (ctl.wrLine[b]),
      .wrStat  (ctl.wrStat[b]),
      .wrData  (ctl.wrData),
      .stat    (statV[b]),
      .lineMask(lineV[b]),
      .statMask(smskV[b]),
      .pend    (pendV[b])
    );
  end

  always_comb begin
    rdMux = '0;
    for (int b = 0; b < BANK_CNT; b++) begin
      if (ctl.rdAddr == ADDR_W'(b))             rdMux = statV[b];
      if (ctl.rdAddr == ADDR_W'(LINE_BASE + b)) rdMux = lineV[b];
      if (ctl.rdAddr == ADDR_W'(SMSK_BASE + b)) rdMux = smskV[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.rdEn;
      if (ctl.rdEn) rdData <= rdMux;
    end
  end

  assign irqOut = |pendV;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdEn |=> rdValid);
  a_r11_valid_only: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> !rdValid);
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_CNT-1:0] srcEvt,
  input  logic               hostStart,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               hostWrEn,
  input  logic [BANK_W-1:0]  hostWrData,
  input  logic               hostRdEn,
  output logic [BANK_W-1:0]  hostRdData,
  output logic               hostRdValid,
  output logic               irqOut
);
  ctlStrobe_t ctl;

  irq_agg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostStart (hostStart),
    .hostAddr  (hostAddr),
    .hostWrEn  (hostWrEn),
    .hostWrData(hostWrData),
    .hostRdEn  (hostRdEn),
    .ctl       (ctl)
  );

  irq_agg_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcEvt (srcEvt),
    .ctl    (ctl),
    .rdData (hostRdData),
    .rdValid(hostRdValid),
    .irqOut (irqOut)
  );

  a_r1_irq_low_reset: assert property (@(posedge clk) $rose(rstN) |-> !irqOut);
endmodule

// File: tb/sim_evt_irq_agg.sv
`timescale 1ns/1ps
module sim_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] srcEvt = '0;
  logic        hostStart = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [7:0]  hostRdData;
  logic        hostRdValid;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  evt_irq_agg u0 (
    .clk(clk), .rstN(rstN), .srcEvt(srcEvt), .hostStart(hostStart),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .hostRdValid(hostRdValid),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per valid read result
  always @(negedge clk) begin
    if (hostRdValid) begin
      if (expQ.size() == 0) check("R11 unexpected read result", 8'h01, 8'h00);
      else check(tagQ.pop_front(), hostRdData, expQ.pop_front());
    end
  end

  task automatic clearBus();
    hostStart = 1'b0; hostWrEn = 1'b0; hostRdEn = 1'b0;
  endtask

  task automatic rdBurst(input logic [3:0] a, input int n,
                         input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hostStart = (i == 0); hostAddr = a; hostRdEn = 1'b1;
      expQ.push_back(i == 0 ? e0 : (i == 1 ? e1 : e2));
      tagQ.push_back(tag);
    end
    @(negedge clk); clearBus();
  endtask

  task automatic rd1(input logic [3:0] a, input logic [7:0] e, input string tag);
    rdBurst(a, 1, e, 8'h00, 8'h00, tag);
  endtask

  task automatic wrBurst(input logic [3:0] a, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hostStart = (i == 0); hostAddr = a; hostWrEn = 1'b1;
      hostWrData = (i == 0) ? d0 : ((i == 1) ? d1 : d2);
    end
    @(negedge clk); clearBus();
  endtask

  task automatic wr1(input logic [3:0] a, input logic [7:0] d);
    wrBurst(a, 1, d, 8'h00, 8'h00);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); srcEvt[n] = 1'b1;
    @(negedge clk); srcEvt[n] = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    check(tag, {7'd0, irqOut}, {7'd0, e});
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog expired", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkIrq(1'b0, "R1 irq after reset");
    check("R1 valid after reset", {7'd0, hostRdValid}, 8'h00);
    rdBurst(4'h0, 3, 8'h00, 8'h00, 8'h00, "R1 status reset");
    rdBurst(4'h3, 3, 8'hFF, 8'hFF, 8'hFF, "R1 line mask reset");
    rdBurst(4'h6, 3, 8'hFF, 8'hFF, 8'hFF, "R1 status mask reset");
    // R3 masked edge not recorded, also not after unmask
    pulse(5);
    wr1(4'h6, 8'h00);
    rd1(4'h0, 8'h00, "R3 masked edge lost");
    // R9 burst write of status masks
    wrBurst(4'h6, 3, 8'h00, 8'h00, 8'h00);
    rdBurst(4'h6, 3, 8'h00, 8'h00, 8'h00, "R9 burst mask write");
    // R2 mapping, R7 reserved
    pulse(0); pulse(9); pulse(12); pulse(17); pulse(23);
    rdBurst(4'h0, 3, 8'h01, 8'h02, 8'h02, "R2 R7 mapping");
    chkIrq(1'b0, "R8 all lines masked");
    // R8 line unmask takes effect next clock
    @(negedge clk);
    hostStart = 1'b1; hostAddr = 4'h4; hostWrEn = 1'b1; hostWrData = 8'hFD;
    chkIrq(1'b0, "R8 before line write");
    @(negedge clk); clearBus();
    chkIrq(1'b1, "R8 after line write");
    // R4 hold with steady-high source
    @(negedge clk); srcEvt[3] = 1'b1;
    repeat (5) @(negedge clk);
    rd1(4'h0, 8'h09, "R4 hold");
    // R5 group clear via bank 2 address, R2 steady level does not re-set
    wr1(4'h2, 8'h5A);
    chkIrq(1'b0, "R8 irq after clear");
    rdBurst(4'h0, 3, 8'h00, 8'h00, 8'h00, "R5 R2 cleared, level ignored");
    srcEvt[3] = 1'b0;
    // R6 edge coinciding with clear
    @(negedge clk);
    srcEvt[20] = 1'b1; hostStart = 1'b1; hostAddr = 4'h0; hostWrEn = 1'b1; hostWrData = 8'h33;
    @(negedge clk); srcEvt[20] = 1'b0; clearBus();
    rdBurst(4'h0, 3, 8'h00, 8'h00, 8'h10, "R6 edge kept");
    chkIrq(1'b0, "R8 bank2 line masked");
    wr1(4'h5, 8'hEF);
    chkIrq(1'b1, "R8 bank2 line open");
    // R3 per-bit status mask
    wr1(4'h7, 8'h04);
    pulse(10); pulse(11);
    rd1(4'h1, 8'h08, "R3 per-bit mask");
    // R10 unmapped reads and writes
    rd1(4'h9, 8'h00, "R10 read 0x9");
    rd1(4'hF, 8'h00, "R10 read 0xF");
    wr1(4'hC, 8'h00);
    wr1(4'h9, 8'h00);
    rdBurst(4'h3, 3, 8'hFF, 8'hFD, 8'hEF, "R10 line masks unchanged");
    rdBurst(4'h6, 3, 8'h00, 8'h04, 8'h00, "R10 status masks unchanged");
    rdBurst(4'h0, 3, 8'h00, 8'h08, 8'h10, "R10 status unchanged");
    repeat (3) @(negedge clk);
    // R11 every read strobe produced exactly one result
    check("R11 all reads returned", 8'(expQ.size()), 8'h00);
    check("R11 valid idle", {7'd0, hostRdValid}, 8'h00);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule